// File: doc/BRIEF.md
# Not-Present Translation Filter

This block is a small fully associative store, kept next to the main TLB, that holds virtual page numbers whose page table walk ended on a not-present entry. A speculative access that misses the TLB probes the filter first. On a hit, the walker does not start a walk for that page. Repeated wrong-path misses to the same unmapped page therefore do not each pay for a walk.

The negative entries live only here, so they never take a slot from a valid translation. The walker writes a page in through the insert port when a walk returns not-present. Page table changes remove entries, either all of them through a flush or one page through an invalidate. When a fault for a page reaches commit, the filter drops that page. One cycle later it asks for a fresh walk, so the fault is reported against current page tables rather than a stale speculative result.

Top module: `neg_xlat_filter`

## Requirements
- R1: After reset no page hits and `rewalk_req` is 0.
- R2: `lk_hit` is combinational. In the cycle of the probe it is 1 when `lk_valid` is 1 and `lk_vpn` matches a stored page, and 0 otherwise. It is always 0 while `lk_valid` is 0.
- R3: A page inserted in a cycle hits from the next cycle on.
- R4: Inserting a page that is already stored allocates no second slot, so the filter's capacity stays unchanged.
- R5: An insert goes to the lowest-numbered free slot. When all 8 slots are full, it replaces the slot at a round-robin pointer. The pointer starts at slot 0, advances by one after each such replacement, and wraps after the last slot.
- R6: `flush_all` empties the filter and returns the round-robin pointer to slot 0. An insert in the same cycle as a flush is dropped.
- R7: An invalidate removes only the named page. Other stored pages keep hitting.
- R8: A commit fault removes its page. `rewalk_req` is then 1 for exactly the next cycle, with `rewalk_vpn` equal to the faulting page.
- R9: An insert is dropped when an invalidate or a commit fault names the same page in the same cycle.
- R10: A probe made in the same cycle as an insert of that page sees the state from before the insert.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Probe request |
| lk_vpn | input | VPN_W | Page being probed |
| lk_hit | output | 1 | Page is known not-present; suppress the walk |
| ins_valid | input | 1 | Walk finished with a not-present result |
| ins_vpn | input | VPN_W | Page to record |
| flush_all | input | 1 | Clear every entry |
| inv_valid | input | 1 | Remove one page |
| inv_vpn | input | VPN_W | Page to remove |
| cf_valid | input | 1 | Fault reached commit |
| cf_vpn | input | VPN_W | Faulting page |
| rewalk_req | output | 1 | One-cycle request for a fresh walk |
| rewalk_vpn | output | VPN_W | Page to walk again |

## Verification
`lk_hit` is due in the same cycle as the probe. The bench drives the probe at the falling edge and samples a moment later, before any rising edge. Inserts, flushes and removals take effect at the next rising edge, so their results are probed at the following falling edge. `rewalk_req` is checked at the falling edge one cycle after the fault and again one cycle later to confirm it has dropped back to 0.

// File: rtl/neg_xlat_filter.sv
module neg_xlat_filter #(
  parameter int ENTRIES = 8,
  parameter int VPN_W   = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lk_valid,
  input  logic [VPN_W-1:0] lk_vpn,
  output logic             lk_hit,
  input  logic             ins_valid,
  input  logic [VPN_W-1:0] ins_vpn,
  input  logic             flush_all,
  input  logic             inv_valid,
  input  logic [VPN_W-1:0] inv_vpn,
  input  logic             cf_valid,
  input  logic [VPN_W-1:0] cf_vpn,
  output logic             rewalk_req,
  output logic [VPN_W-1:0] rewalk_vpn
);
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

  logic [ENTRIES-1:0] vld;
  logic [VPN_W-1:0]   tag [ENTRIES];
  logic [ENTRIES-1:0] lk_m, ins_m, inv_m, cf_m;
  logic [IDX_W-1:0]   rr, free_idx, victim;
  logic               have_free, ins_ok;
  logic [ENTRIES-1:0] kill;

  for (genvar gi = 0; gi < ENTRIES; gi++) begin : g_cmp
    assign lk_m[gi]  = vld[gi] && (tag[gi] == lk_vpn);
    assign ins_m[gi] = vld[gi] && (tag[gi] == ins_vpn);
    assign inv_m[gi] = vld[gi] && (tag[gi] == inv_vpn);
    assign cf_m[gi]  = vld[gi] && (tag[gi] == cf_vpn);
  end

  assign lk_hit = lk_valid && (|lk_m);
  assign kill   = ({ENTRIES{inv_valid}} & inv_m) | ({ENTRIES{cf_valid}} & cf_m);
  assign ins_ok = ins_valid && !flush_all && !(|ins_m)
                  && !(inv_valid && inv_vpn == ins_vpn)
                  && !(cf_valid && cf_vpn == ins_vpn);

  always_comb begin
    have_free = 1'b0;
    free_idx  = '0;
    for (int i = ENTRIES - 1; i >= 0; i--)
      if (!vld[i]) begin
        have_free = 1'b1;
        free_idx  = IDX_W'(i);
      end
  end

  assign victim = have_free ? free_idx : rr;

  always_ff @(posedge clk) begin
    if (!rst_n || flush_all) begin
      vld <= '0;
      rr  <= '0;
    end else begin
      vld <= vld & ~kill;
      if (ins_ok) begin
        vld[victim] <= 1'b1;
        if (!have_free) rr <= (rr == LAST) ? '0 : rr + 1'b1;
      end
    end
  end

  always_ff @(posedge clk)
    if (ins_ok) tag[victim] <= ins_vpn;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rewalk_req <= 1'b0;
      rewalk_vpn <= '0;
    end else begin
      rewalk_req <= cf_valid;
      if (cf_valid) rewalk_vpn <= cf_vpn;
    end
  end
endmodule

// File: rtl/neg_xlat_filter_chk.sv
module neg_xlat_filter_chk #(
  parameter int VPN_W = 20
) (
  input logic             clk,
  input logic             rst_n,
  input logic             lk_valid,
  input logic [VPN_W-1:0] lk_vpn,
  input logic             lk_hit,
  input logic             ins_valid,
  input logic [VPN_W-1:0] ins_vpn,
  input logic             flush_all,
  input logic             inv_valid,
  input logic [VPN_W-1:0] inv_vpn,
  input logic             cf_valid,
  input logic [VPN_W-1:0] cf_vpn,
  input logic             rewalk_req,
  input logic [VPN_W-1:0] rewalk_vpn
);
  a_r2_idle_no_hit: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |-> !lk_hit);

  a_r3_insert_hits: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_valid && !flush_all && !(inv_valid && inv_vpn == ins_vpn)
     && !(cf_valid && cf_vpn == ins_vpn))
    |=> (!(lk_valid && lk_vpn == $past(ins_vpn)) || lk_hit));

  a_r6_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
    flush_all |=> !lk_hit);

  a_r7_inv_removes: assert property (@(posedge clk) disable iff (!rst_n)
    inv_valid |=> !(lk_valid && lk_vpn == $past(inv_vpn) && lk_hit));

  a_r8_rewalk_follows: assert property (@(posedge clk) disable iff (!rst_n)
    cf_valid |=> (rewalk_req && rewalk_vpn == $past(cf_vpn)));

  a_r8_fault_removes: assert property (@(posedge clk) disable iff (!rst_n)
    cf_valid |=> !(lk_valid && lk_vpn == $past(cf_vpn) && lk_hit));
endmodule

bind neg_xlat_filter neg_xlat_filter_chk #(.VPN_W(VPN_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_vpn(lk_vpn),
  .lk_hit(lk_hit), .ins_valid(ins_valid), .ins_vpn(ins_vpn),
  .flush_all(flush_all), .inv_valid(inv_valid), .inv_vpn(inv_vpn),
  .cf_valid(cf_valid), .cf_vpn(cf_vpn), .rewalk_req(rewalk_req),
  .rewalk_vpn(rewalk_vpn)
);

// File: tb/sim_neg_xlat_filter.sv
`timescale 1ns/1ps
module sim_neg_xlat_filter;
  localparam int VW = 20;
  logic clk = 1'b0, rst_n = 1'b0;
  logic lk_valid = 0, ins_valid = 0, flush_all = 0, inv_valid = 0, cf_valid = 0;
  logic [VW-1:0] lk_vpn = '0, ins_vpn = '0, inv_vpn = '0, cf_vpn = '0;
  logic lk_hit, rewalk_req;
  logic [VW-1:0] rewalk_vpn;
  int n_chk = 0, n_fail = 0;

  always #4 clk = ~clk;

  neg_xlat_filter #(.ENTRIES(8), .VPN_W(VW)) u0 (
    .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_vpn(lk_vpn), .lk_hit(lk_hit),
    .ins_valid(ins_valid), .ins_vpn(ins_vpn), .flush_all(flush_all),
    .inv_valid(inv_valid), .inv_vpn(inv_vpn), .cf_valid(cf_valid), .cf_vpn(cf_vpn),
    .rewalk_req(rewalk_req), .rewalk_vpn(rewalk_vpn));

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic probe(logic [VW-1:0] v, bit exp, string req);
    lk_valid = 1; lk_vpn = v; #1;
    chk(req, 32'(lk_hit), 32'(exp));
    lk_valid = 0;
  endtask

  task automatic step; @(negedge clk); endtask

  task automatic put(logic [VW-1:0] v);
    ins_valid = 1; ins_vpn = v; step(); ins_valid = 0;
  endtask

  task automatic do_flush;
    flush_all = 1; step(); flush_all = 0;
  endtask

  task automatic t_reset;
    probe(20'h00000, 0, "R1 empty after reset");
    probe(20'h00011, 0, "R1 empty after reset");
    chk("R1 rewalk idle", 32'(rewalk_req), 0);
  endtask

  task automatic t_basic;
    put(20'h00011);
    probe(20'h00011, 1, "R2 stored page hits");
    probe(20'h00012, 0, "R2 other page misses");
    lk_vpn = 20'h00011; #1;
    chk("R2 no hit without lk_valid", 32'(lk_hit), 0);
  endtask

  task automatic t_same_cycle;
    ins_valid = 1; ins_vpn = 20'h00033;
    probe(20'h00033, 0, "R10 probe sees old state");
    step(); ins_valid = 0;
    probe(20'h00033, 1, "R3 hit next cycle");
  endtask

  task automatic t_dup;
    do_flush();
    for (int i = 0; i < 7; i++) put(VW'(20'h100 + i));
    put(20'h00100);
    put(20'h00107);
    put(20'h00108);
    probe(20'h00100, 0, "R4 oldest evicted, no duplicate slot");
    probe(20'h00101, 1, "R4 second page kept");
    probe(20'h00108, 1, "R4 newest stored");
  endtask

  task automatic t_rr;
    do_flush();
    for (int i = 0; i < 8; i++) put(VW'(20'h200 + i));
    for (int i = 0; i < 8; i++) probe(VW'(20'h200 + i), 1, "R5 all eight stored");
    put(20'h00300);
    probe(20'h00200, 0, "R5 slot 0 replaced");
    put(20'h00301);
    probe(20'h00201, 0, "R5 slot 1 replaced");
    probe(20'h00202, 1, "R5 slot 2 kept");
    probe(20'h00301, 1, "R5 new page stored");
  endtask

  task automatic t_flush;
    flush_all = 1; ins_valid = 1; ins_vpn = 20'h00400; step();
    flush_all = 0; ins_valid = 0;
    probe(20'h00400, 0, "R6 insert dropped by flush");
    probe(20'h00202, 0, "R6 flush cleared entries");
    for (int i = 0; i < 9; i++) put(VW'(20'h500 + i));
    probe(20'h00500, 0, "R6 pointer back at slot 0");
    probe(20'h00501, 1, "R6 slot 1 kept");
  endtask

  task automatic t_inv;
    do_flush();
    put(20'h00A00); put(20'h00A01);
    inv_valid = 1; inv_vpn = 20'h00A00; step(); inv_valid = 0;
    probe(20'h00A00, 0, "R7 named page removed");
    probe(20'h00A01, 1, "R7 other page kept");
  endtask

  task automatic t_commit;
    put(20'h00C00);
    cf_valid = 1; cf_vpn = 20'h00C00; step(); cf_valid = 0;
    chk("R8 rewalk pulse", 32'(rewalk_req), 1);
    chk("R8 rewalk page", 32'(rewalk_vpn), 32'h00C00);
    probe(20'h00C00, 0, "R8 faulting page removed");
    step();
    chk("R8 pulse one cycle", 32'(rewalk_req), 0);
  endtask

  task automatic t_race;
    ins_valid = 1; ins_vpn = 20'h00D00; inv_valid = 1; inv_vpn = 20'h00D00; step();
    ins_valid = 0; inv_valid = 0;
    probe(20'h00D00, 0, "R9 insert dropped by invalidate");
    ins_valid = 1; ins_vpn = 20'h00D01; cf_valid = 1; cf_vpn = 20'h00D01; step();
    ins_valid = 0; cf_valid = 0;
    probe(20'h00D01, 0, "R9 insert dropped by commit fault");
    probe(20'h00A01, 1, "R9 unrelated page kept");
  endtask

  initial begin
    repeat (3) step();
    rst_n = 1; step();
    t_reset(); t_basic(); t_same_cycle(); t_dup(); t_rr();
    t_flush(); t_inv(); t_commit(); t_race();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule